// File: doc/BRIEF.md
# Extended-Precision to Signed Integer Converter

This block turns an 80-bit extended-precision floating-point operand into a signed 32-bit integer. The rounding direction is chosen on every conversion from four options. A caller places the operand and the rounding mode on the inputs and pulses `start`. A fixed two cycles later, `done` pulses for one cycle. In that same cycle the integer result and two flags are valid: one flag marks an invalid conversion and the other marks a lost fraction. The outputs then hold until the next result.

The operand has three fields. The sign is bit 79. The biased exponent is bits 78..64, with a bias of 3FFFh. The significand is bits 63..0, and its integer bit is stored explicitly at bit 63. The block aligns the significand by the unbiased exponent. It keeps the integer part and reduces the discarded bits to a round bit and a sticky bit. It then applies the selected rounding rule, checks the rounded magnitude against the signed range, and applies the sign. A new `start` may be given on every cycle.

Top module: `ext_to_int_rounder`

## Requirements
- R1: The operand is decoded as sign bit 79, biased exponent bits 78..64 (bias 3FFFh) and significand bits 63..0, so the value is significand × 2^(exponent − 3FFFh − 63). A value that is an exact integer in range converts to that integer with both flags low.
- R2: With `rmode` = 00, the result is the nearest integer, and a value exactly halfway between two integers goes to the even one (5.64 gives 6, 2.5 gives 2, −1.5 gives −2).
- R3: With `rmode` = 01, the result rounds toward minus infinity.
- R4: With `rmode` = 10, the result rounds toward plus infinity.
- R5: With `rmode` = 11, the result rounds toward zero, which drops the fraction.
- R6: A negative operand produces the two's complement of the rounded magnitude. A negative result never comes from a positive operand, and a negative operand that rounds to zero gives 0.
- R7: When no invalid condition occurs, `inexact` is high exactly when the rounded result differs from the operand's exact value.
- R8: An operand with exponent field 7FFFh (infinity or NaN) gives result 80000000h, `invalid` high and `inexact` low.
- R9: A rounded value above 2147483647 or below −2147483648 gives result 80000000h, `invalid` high and `inexact` low. A rounded value of exactly −2147483648 is valid.
- R10: `done` rises exactly two cycles after the cycle in which `start` is sampled high, once for each start. Back-to-back starts are accepted on every cycle. `result`, `invalid` and `inexact` change only in a cycle where `done` is high.
- R11: After reset, `done`, `result`, `invalid` and `inexact` are all zero.
- R12: Zero, denormal and very small operands, including unbiased exponents below −64, convert to 0 or ±1 as the mode directs. `inexact` is high whenever the significand is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a conversion of `operand` with `rmode` |
| operand | input | 80 | Extended-precision value: sign, 15-bit exponent, 64-bit significand |
| rmode | input | 2 | Rounding mode: 00 nearest-even, 01 down, 10 up, 11 toward zero |
| result | output | 32 | Signed integer result |
| done | output | 1 | One-cycle pulse marking a valid result |
| invalid | output | 1 | Operand is infinite or NaN, or the rounded value is out of range |
| inexact | output | 1 | Rounding discarded a nonzero fraction |

## Verification
The bench builds the block with its default parameters. These are a 32-bit integer result, a 15-bit exponent and a 64-bit significand. With these values, both range edges, ±2^31, can be reached exactly with half-unit fractions, as can ties and values with a fraction of one part in 2^64. Every test value is applied in all four rounding modes. Expected integers come from floor, ceiling and tie decisions taken on exact double-precision values. Raw encodings cover infinity, NaN, zero, denormals and exponents far below the rounding position.

// File: rtl/ext_to_int_rounder.sv
module ext_to_int_rounder #(
  parameter int INT_W = 32,
  parameter int EXP_W = 15,
  parameter int SIG_W = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [SIG_W+EXP_W:0]   operand,
  input  logic [1:0]             rmode,
  output logic [INT_W-1:0]       result,
  output logic                   done,
  output logic                   invalid,
  output logic                   inexact
);

  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int KW   = EXP_W + 2;
  localparam int WIDE = 2 * SIG_W;
  localparam int SHW  = $clog2(WIDE);
  localparam logic signed [KW-1:0] K_LO = KW'(-SIG_W);
  localparam logic signed [KW-1:0] K_HI = KW'(SIG_W - 1);
  localparam logic signed [KW-1:0] K_BIAS = KW'(BIAS);
  localparam logic [SIG_W:0] NEG_LIM = {{(SIG_W-INT_W+1){1'b0}}, 1'b1, {(INT_W-1){1'b0}}};
  localparam logic [SIG_W:0] POS_LIM = NEG_LIM - 1'b1;
  localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

  localparam logic [1:0] RM_NEAR = 2'b00;
  localparam logic [1:0] RM_DOWN = 2'b01;
  localparam logic [1:0] RM_UP   = 2'b10;
  localparam logic [1:0] RM_ZERO = 2'b11;

  // field split and alignment
  logic                 sgn;
  logic [EXP_W-1:0]     ex;
  logic [SIG_W-1:0]     sig;
  logic signed [KW-1:0] k;
  logic                 special, tiny, huge;
  logic [SHW-1:0]       sh;
  logic [WIDE-1:0]      wide;

  assign sgn     = operand[SIG_W+EXP_W];
  assign ex      = operand[SIG_W+EXP_W-1:SIG_W];
  assign sig     = operand[SIG_W-1:0];
  assign k       = $signed({2'b00, ex}) - K_BIAS;
  assign special = &ex;
  assign tiny    = k < K_LO;
  assign huge    = k > K_HI;
  assign sh      = SHW'(SIG_W - 1) - k[SHW-1:0];
  assign wide    = {sig, {SIG_W{1'b0}}} >> sh;

  logic [SIG_W-1:0] q_c;
  logic             r_c, s_c;

  always_comb begin
    if (tiny) begin
      q_c = '0;
      r_c = 1'b0;
      s_c = |sig;
    end else if (huge) begin
      q_c = '0;
      r_c = 1'b0;
      s_c = 1'b0;
    end else begin
      q_c = wide[WIDE-1:SIG_W];
      r_c = wide[SIG_W-1];
      s_c = |wide[SIG_W-2:0];
    end
  end

  // stage 1
  logic [SIG_W-1:0] q1;
  logic             r1, s1, sgn1, bad1, v1;
  logic [1:0]       mode1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1    <= 1'b0;
      q1    <= '0;
      r1    <= 1'b0;
      s1    <= 1'b0;
      sgn1  <= 1'b0;
      bad1  <= 1'b0;
      mode1 <= RM_NEAR;
    end else begin
      v1 <= start;
      if (start) begin
        q1    <= q_c;
        r1    <= r_c;
        s1    <= s_c;
        sgn1  <= sgn;
        bad1  <= special | (huge & (|sig));
        mode1 <= rmode;
      end
    end
  end

  // rounding, range and sign
  logic             inc;
  logic [SIG_W:0]   mag;
  logic             ovf;
  logic [INT_W-1:0] ires, res_n;

  always_comb begin
    unique case (mode1)
      RM_NEAR: inc = r1 & (s1 | q1[0]);
      RM_DOWN: inc = (r1 | s1) & sgn1;
      RM_UP:   inc = (r1 | s1) & ~sgn1;
      RM_ZERO: inc = 1'b0;
      default: inc = 1'b0;
    endcase
  end

  assign mag   = {1'b0, q1} + {{SIG_W{1'b0}}, inc};
  assign ovf   = bad1 | (mag > (sgn1 ? NEG_LIM : POS_LIM));
  assign ires  = mag[INT_W-1:0];
  assign res_n = ovf ? INDEF : (sgn1 ? (~ires + 1'b1) : ires);

  // stage 2
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done    <= 1'b0;
      result  <= '0;
      invalid <= 1'b0;
      inexact <= 1'b0;
    end else begin
      done <= v1;
      if (v1) begin
        result  <= res_n;
        invalid <= ovf;
        inexact <= ~ovf & (r1 | s1);
      end
    end
  end

  assert_done_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ##1 done);

  assert_hold_between_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result) && $stable(invalid) && $stable(inexact)));

  assert_indefinite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && invalid) |-> (result == INDEF && !inexact));

  assert_sign_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !invalid && result[INT_W-1]) |-> $past(operand[SIG_W+EXP_W], 2));

endmodule

// File: tb/ext_to_int_rounder_test.sv
module ext_to_int_rounder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [79:0] operand = '0;
  logic [1:0]  rmode = 2'b00;
  logic [31:0] result;
  logic        done, invalid, inexact;

  int errors = 0;
  int checks = 0;
  logic [33:0] exp_q[$];
  string       tag_q[$];
  bit          finished = 0;

  always #2 clk = ~clk;

  ext_to_int_rounder uut (
    .clk(clk), .rst_n(rst_n), .start(start), .operand(operand), .rmode(rmode),
    .result(result), .done(done), .invalid(invalid), .inexact(inexact)
  );

  task automatic chk(input bit ok, input string tag, input logic [33:0] act, input logic [33:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual inv=%0b inx=%0b res=%h expected inv=%0b inx=%0b res=%h",
               tag, act[33], act[32], act[31:0], expv[33], expv[32], expv[31:0]);
    end
  endtask

  function automatic logic [79:0] enc(input real v);
    logic [63:0] b;
    logic [14:0] e;
    b = $realtobits(v);
    if (b[62:52] == 11'd0) return {b[63], 79'd0};
    e = 15'(int'(b[62:52]) - 1023 + 16383);
    return {b[63], e, 1'b1, b[51:0], 11'd0};
  endfunction

  function automatic logic [33:0] model(input real v, input logic [1:0] m);
    real f, rnd, d;
    longint li;
    f = $floor(v);
    case (m)
      2'b00: begin
        d = v - f;
        if (d > 0.5) rnd = f + 1.0;
        else if (d < 0.5) rnd = f;
        else rnd = ($floor(f / 2.0) * 2.0 == f) ? f : f + 1.0;
      end
      2'b01: rnd = f;
      2'b10: rnd = $ceil(v);
      default: rnd = (v < 0.0) ? $ceil(v) : f;
    endcase
    if (rnd > 2147483647.0 || rnd < -2147483648.0) return {2'b10, 32'h8000_0000};
    li = longint'(rnd);
    return {1'b0, (rnd != v), li[31:0]};
  endfunction

  task automatic send_raw(input logic [79:0] op, input logic [1:0] m, input logic [33:0] expv, input string tag);
    operand = op;
    rmode = m;
    start = 1'b1;
    exp_q.push_back(expv);
    tag_q.push_back(tag);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send_val(input real v, input string tag);
    for (int m = 0; m < 4; m++)
      send_raw(enc(v), 2'(m), model(v, 2'(m)), $sformatf("%s v=%f mode=%0d", tag, v, m));
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected done", {invalid, inexact, result}, '0);
      end else begin
        logic [33:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({invalid, inexact, result} == e, t, {invalid, inexact, result}, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({invalid, inexact, result, done} == 35'd0, "R11 reset state",
        {invalid, inexact, result}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 R5 R6 R7 value sweep in every mode
    send_val(5.64, "R2");
    send_val(-5.64, "R6");
    send_val(0.5, "R2");
    send_val(-0.5, "R6");
    send_val(1.5, "R2");
    send_val(-1.5, "R6");
    send_val(2.5, "R2");
    send_val(-2.5, "R3");
    send_val(1.4375, "R4");
    send_val(-1.4375, "R5");
    send_val(1000000.0, "R1 R7");
    send_val(-7.0, "R1");
    send_val(3.75, "R5");
    send_val(0.0, "R12");
    // R9 range edges
    send_val(2147483647.0, "R9");
    send_val(2147483647.5, "R9");
    send_val(2147483646.5, "R9");
    send_val(-2147483648.0, "R9");
    send_val(-2147483648.5, "R9");
    send_val(-2147483647.5, "R9");
    send_val(4294967296.0, "R9");
    send_val(-1.0e12, "R9");

    // R8 infinity and NaN
    send_raw({1'b0, 15'h7FFF, 64'h8000_0000_0000_0000}, 2'b00, {2'b10, 32'h8000_0000}, "R8 +inf");
    send_raw({1'b1, 15'h7FFF, 64'h8000_0000_0000_0000}, 2'b11, {2'b10, 32'h8000_0000}, "R8 -inf");
    send_raw({1'b0, 15'h7FFF, 64'hC000_0000_0000_0000}, 2'b10, {2'b10, 32'h8000_0000}, "R8 NaN");

    // R12 zero, denormal, far-tiny
    send_raw({1'b1, 15'h0000, 64'h0}, 2'b01, {2'b00, 32'd0}, "R12 -zero");
    send_raw({1'b0, 15'h0000, 64'h1}, 2'b10, {2'b01, 32'd1}, "R12 denorm up");
    send_raw({1'b1, 15'h0000, 64'h1}, 2'b01, {2'b01, 32'hFFFF_FFFF}, "R12 denorm down");
    send_raw({1'b0, 15'h0000, 64'h1}, 2'b00, {2'b01, 32'd0}, "R12 denorm near");
    send_raw({1'b0, 15'h0001, 64'h8000_0000_0000_0000}, 2'b10, {2'b01, 32'd1}, "R12 tiny up");
    // R7 sticky from the lowest significand bit: 1 + 2^-63
    send_raw({1'b0, 15'h3FFF, 64'h8000_0000_0000_0001}, 2'b10, {2'b01, 32'd2}, "R7 low sticky up");
    send_raw({1'b0, 15'h3FFF, 64'h8000_0000_0000_0001}, 2'b00, {2'b01, 32'd1}, "R7 low sticky near");
    // R2 tie to odd neighbour then even: 3.5 -> 4
    send_raw({1'b0, 15'h4000, 64'hE000_0000_0000_0000}, 2'b00, {2'b01, 32'd4}, "R2 3.5 tie");

    repeat (4) @(negedge clk);

    // R10 latency of an isolated start
    send_raw(enc(9.0), 2'b00, {2'b00, 32'd9}, "R10 isolated");
    chk(done == 1'b0, "R10 done early", {33'd0, done}, 34'd0);
    @(negedge clk);
    chk(done == 1'b1, "R10 done at two cycles", {33'd0, done}, 34'd1);
    @(negedge clk);
    chk(done == 1'b0, "R10 single pulse", {33'd0, done}, 34'd0);
    chk(result == 32'd9, "R10 result holds", {2'b00, result}, {2'b00, 32'd9});

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all results delivered", 34'(exp_q.size()), 34'd0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule